// File: doc/BRIEF.md
# Fieldbus Gateway Message Translator

This block is the bus-facing engine of a two-bus gateway. Frames from the local fieldbus controller arrive on a valid/ready stream: each carries an 11-bit station identifier, a byte count and up to eight payload bytes. The first payload byte is a command code. Code 00H delivers two data bytes, which are stored in the station's two-byte slot in a shared mailbox memory. Code FFH asks the far side for a station's data. In both cases the engine then records the station number in a hand-off cell and rings the far side's doorbell.

When the far side rings this engine's doorbell (the `mbx_irq` level), the engine reads its own doorbell cell, which clears the interrupt. It then reads the target station cell and builds one outgoing frame. That frame either returns the station's stored slot bytes or forwards a request for them. The frame is presented on a valid/ready output only once all of its bytes are assembled. A pending doorbell is always served before the next received frame is accepted. Station-to-slot mapping is arithmetic: station n owns bytes 2n and 2n+1, for stations below `N_STATIONS`.

Back-pressure rules: a received frame is transferred on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while the engine is idle and no doorbell is pending. An outgoing frame is transferred when `tx_valid` and `tx_ready` are both high. Once `tx_valid` rises, it and the frame fields hold steady until that transfer. The memory port has one cycle of read latency: `mem_rdata` reflects the address presented with `mem_re` on the previous edge.

Top module: `gw_translator`

## Requirements
- R1: After reset `tx_valid`, `mem_we`, `mem_re` and `lookup_err` are low, and `rx_ready` is high while `mbx_irq` is low.
- R2: A received frame with payload byte 0 = 00H, length of at least 3 and station id below 128 produces exactly four writes, in this order: slot byte 2·id ← payload byte 1, byte 2·id+1 ← payload byte 2, 3FCH ← id, 3FFH ← 00H.
- R3: A received frame with payload byte 0 = FFH and length of at least 2 produces exactly two writes: 3FCH ← payload byte 1, then 3FFH ← FFH.
- R4: A received frame with any other code, a 00H code with length below 3, or an FFH code with length below 2 causes no memory write and no `lookup_err`.
- R5: A 00H-code frame whose station id is 128 or more causes no memory write and a `lookup_err` pulse of exactly one cycle.
- R6: On a doorbell, the engine reads 3FEH (clearing the doorbell) before it reads 3FDH. If 3FEH holds 00H, it emits a frame with id = station from 3FDH, length 3, and payload {00H, slot byte 2·station, slot byte 2·station+1}.
- R7: If 3FEH holds FFH, the engine emits a frame with id = station from 3FDH, length 2, and payload {FFH, station}.
- R8: Any other doorbell code produces no frame. A 00H doorbell code for station 128 or more produces no frame and a one-cycle `lookup_err`.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_id`, `tx_len` and `tx_data` hold their values. Each frame is transferred once.
- R10: While `mbx_irq` is high, `rx_ready` is low. A doorbell pending together with a waiting frame is finished, including its output transfer, before any write for that frame.
- R11: `rx_ready` is low while a job is in progress. The engine writes only to slot bytes below 2·`N_STATIONS`, to 3FCH and to 3FFH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received frame offered |
| rx_ready | output | 1 | Engine accepts a frame this cycle |
| rx_id | input | 11 | Station identifier of received frame |
| rx_len | input | 4 | Payload byte count (0..8) |
| rx_data | input | 64 | Payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Outgoing frame available |
| tx_ready | input | 1 | Transmitter takes the frame |
| tx_id | output | 11 | Station identifier of outgoing frame |
| tx_len | output | 4 | Outgoing payload byte count |
| tx_data | output | 64 | Outgoing payload, byte k at bits 8k+7:8k, unused bytes zero |
| mbx_irq | input | 1 | Doorbell level from the shared memory |
| mem_addr | output | 10 | Shared memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| lookup_err | output | 1 | One-cycle pulse on a station outside the slot table |

## Verification
The hardest case to reach is a collision: a doorbell raised while a received frame is already waiting. The bench raises the doorbell and then offers a frame before the engine has left idle. It checks that `rx_ready` stays low, and that the doorbell's outgoing frame completes before the first slot write for the waiting frame. Back-pressure is reached by holding `tx_ready` low across a full request frame while sampling the held fields. Slot round trips are covered by delivering data on the receive side and later fetching the same station through the doorbell path.

// File: rtl/gw_pkg.sv
package gw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RX_DEC, S_RX_WLO, S_RX_WHI, S_RX_WID, S_RX_BELL,
    S_MB_CMD, S_MB_ID, S_MB_DEC, S_MB_B0, S_MB_B1, S_TX
  } gw_state_e;

  typedef enum logic [1:0] { KIND_DROP, KIND_DATA, KIND_REQ } gw_kind_e;

  localparam logic [7:0] CODE_DATA = 8'h00;
  localparam logic [7:0] CODE_REQ  = 8'hFF;
endpackage

// File: rtl/gw_slot_lut.sv
module gw_slot_lut #(
  parameter int ID_W       = 11,
  parameter int ADDR_W     = 10,
  parameter int N_STATIONS = 128
) (
  input  logic [ID_W-1:0]   id,
  output logic              hit,
  output logic [ADDR_W-1:0] base
);
  generate
    if (N_STATIONS >= (1 << ID_W)) begin : g_full
      assign hit = 1'b1;
    end else begin : g_part
      assign hit = (id < ID_W'(N_STATIONS));
    end
  endgenerate

  assign base = hit ? ADDR_W'({id, 1'b0}) : '0;
endmodule

// File: rtl/gw_rx_classify.sv
module gw_rx_classify
  import gw_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [7:0]       code,
  input  logic [LEN_W-1:0] len,
  output gw_kind_e         kind
);
  always_comb begin
    if (code == CODE_DATA && len >= LEN_W'(3))     kind = KIND_DATA;
    else if (code == CODE_REQ && len >= LEN_W'(2)) kind = KIND_REQ;
    else                                           kind = KIND_DROP;
  end
endmodule

// File: rtl/gw_tx_frame.sv
module gw_tx_frame #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ID_W-1:0]   ld_id,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [DATA_W-1:0] ld_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [ID_W-1:0]   tx_id,
  output logic [LEN_W-1:0]  tx_len,
  output logic [DATA_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_id    <= '0;
      tx_len   <= '0;
      tx_data  <= '0;
    end else if (load && !tx_valid) begin
      tx_valid <= 1'b1;
      tx_id    <= ld_id;
      tx_len   <= ld_len;
      tx_data  <= ld_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gw_translator.sv
module gw_translator
  import gw_pkg::*;
#(
  parameter int ID_W       = 11,
  parameter int ADDR_W     = 10,
  parameter int DATA_BYTES = 8,
  parameter int N_STATIONS = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic [ID_W-1:0]         rx_id,
  input  logic [3:0]              rx_len,
  input  logic [8*DATA_BYTES-1:0] rx_data,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [ID_W-1:0]         tx_id,
  output logic [3:0]              tx_len,
  output logic [8*DATA_BYTES-1:0] tx_data,
  input  logic                    mbx_irq,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic                    mem_re,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata,
  output logic                    lookup_err
);
  localparam int LEN_W  = 4;
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam logic [ADDR_W-1:0] A_HANDOFF = ADDR_W'((1 << ADDR_W) - 4);
  localparam logic [ADDR_W-1:0] A_TARGET  = ADDR_W'((1 << ADDR_W) - 3);
  localparam logic [ADDR_W-1:0] A_OWN_MBX = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] A_PEER_MBX = ADDR_W'((1 << ADDR_W) - 1);

  gw_state_e             state;
  logic [ID_W-1:0]       rx_id_q;
  logic [LEN_W-1:0]      rx_len_q;
  logic [DATA_W-1:0]     rx_data_q;
  logic [7:0]            cmd_q, stn_q, b0_q;
  logic [ADDR_W-1:0]     slot_q;
  logic                  err_q;
  gw_kind_e              kind;
  logic [ID_W-1:0]       lut_id;
  logic                  lut_hit;
  logic [ADDR_W-1:0]     lut_base;
  logic                  ld;
  logic [ID_W-1:0]       ld_id;
  logic [LEN_W-1:0]      ld_len;
  logic [DATA_W-1:0]     ld_data;

  wire [7:0] rx_b1 = rx_data_q[15:8];
  wire [7:0] rx_b2 = rx_data_q[23:16];

  gw_rx_classify #(.LEN_W(LEN_W)) u_cls (
    .code(rx_data_q[7:0]), .len(rx_len_q), .kind(kind)
  );

  assign lut_id = (state == S_MB_DEC) ? ID_W'(mem_rdata) : rx_id_q;

  gw_slot_lut #(.ID_W(ID_W), .ADDR_W(ADDR_W), .N_STATIONS(N_STATIONS)) u_lut (
    .id(lut_id), .hit(lut_hit), .base(lut_base)
  );

  gw_tx_frame #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_txf (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_id(ld_id), .ld_len(ld_len),
    .ld_data(ld_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data)
  );

  assign rx_ready   = (state == S_IDLE) && !mbx_irq;
  assign lookup_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rx_id_q   <= '0;
      rx_len_q  <= '0;
      rx_data_q <= '0;
      cmd_q     <= '0;
      stn_q     <= '0;
      b0_q      <= '0;
      slot_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (mbx_irq) begin
            state <= S_MB_CMD;
          end else if (rx_valid) begin
            rx_id_q   <= rx_id;
            rx_len_q  <= rx_len;
            rx_data_q <= rx_data;
            state     <= S_RX_DEC;
          end
        end
        S_RX_DEC: begin
          case (kind)
            KIND_DATA: begin
              if (lut_hit) begin
                slot_q <= lut_base;
                state  <= S_RX_WLO;
              end else begin
                err_q <= 1'b1;
                state <= S_IDLE;
              end
            end
            KIND_REQ: state <= S_RX_WID;
            default:  state <= S_IDLE;
          endcase
        end
        S_RX_WLO:  state <= S_RX_WHI;
        S_RX_WHI:  state <= S_RX_WID;
        S_RX_WID:  state <= S_RX_BELL;
        S_RX_BELL: state <= S_IDLE;
        S_MB_CMD:  state <= S_MB_ID;
        S_MB_ID: begin
          cmd_q <= mem_rdata;
          state <= S_MB_DEC;
        end
        S_MB_DEC: begin
          stn_q <= mem_rdata;
          if (cmd_q == CODE_DATA) begin
            if (lut_hit) begin
              slot_q <= lut_base;
              state  <= S_MB_B0;
            end else begin
              err_q <= 1'b1;
              state <= S_IDLE;
            end
          end else if (cmd_q == CODE_REQ) begin
            state <= S_TX;
          end else begin
            state <= S_IDLE;
          end
        end
        S_MB_B0: begin
          b0_q  <= mem_rdata;
          state <= S_MB_B1;
        end
        S_MB_B1: state <= S_TX;
        S_TX:    if (tx_valid && tx_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_RX_WLO: begin
        mem_we = 1'b1; mem_addr = slot_q; mem_wdata = rx_b1;
      end
      S_RX_WHI: begin
        mem_we = 1'b1; mem_addr = {slot_q[ADDR_W-1:1], 1'b1}; mem_wdata = rx_b2;
      end
      S_RX_WID: begin
        mem_we    = 1'b1;
        mem_addr  = A_HANDOFF;
        mem_wdata = (kind == KIND_DATA) ? rx_id_q[7:0] : rx_b1;
      end
      S_RX_BELL: begin
        mem_we    = 1'b1;
        mem_addr  = A_PEER_MBX;
        mem_wdata = (kind == KIND_DATA) ? CODE_DATA : CODE_REQ;
      end
      S_MB_CMD: begin mem_re = 1'b1; mem_addr = A_OWN_MBX; end
      S_MB_ID:  begin mem_re = 1'b1; mem_addr = A_TARGET;  end
      S_MB_DEC: begin
        if (cmd_q == CODE_DATA && lut_hit) begin
          mem_re = 1'b1; mem_addr = lut_base;
        end
      end
      S_MB_B0: begin mem_re = 1'b1; mem_addr = {slot_q[ADDR_W-1:1], 1'b1}; end
      default: ;
    endcase
  end

  always_comb begin
    ld      = 1'b0;
    ld_id   = '0;
    ld_len  = '0;
    ld_data = '0;
    if (state == S_MB_DEC && cmd_q == CODE_REQ) begin
      ld            = 1'b1;
      ld_id         = ID_W'(mem_rdata);
      ld_len        = LEN_W'(2);
      ld_data[7:0]  = CODE_REQ;
      ld_data[15:8] = mem_rdata;
    end else if (state == S_MB_B1) begin
      ld             = 1'b1;
      ld_id          = ID_W'(stn_q);
      ld_len         = LEN_W'(3);
      ld_data[7:0]   = CODE_DATA;
      ld_data[15:8]  = b0_q;
      ld_data[23:16] = mem_rdata;
    end
  end
endmodule

// File: rtl/gw_translator_checker.sv
module gw_translator_checker #(
  parameter int ID_W       = 11,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 64,
  parameter int N_STATIONS = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              mbx_irq,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [ID_W-1:0]   tx_id,
  input logic [3:0]        tx_len,
  input logic [DATA_W-1:0] tx_data,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              lookup_err
);
  localparam logic [ADDR_W-1:0] C_HANDOFF  = ADDR_W'((1 << ADDR_W) - 4);
  localparam logic [ADDR_W-1:0] C_TARGET   = ADDR_W'((1 << ADDR_W) - 3);
  localparam logic [ADDR_W-1:0] C_OWN_MBX  = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] C_PEER_MBX = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] C_SPAN     = ADDR_W'(2 * N_STATIONS);

  assert_doorbell_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mbx_irq);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_id) && $stable(tx_len)
                                 && $stable(tx_data)));

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_err |=> !lookup_err);

  assert_write_map_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < C_SPAN || mem_addr == C_HANDOFF || mem_addr == C_PEER_MBX));

  assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  assert_bell_after_handoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == C_HANDOFF) |=> (mem_we && mem_addr == C_PEER_MBX));

  assert_cmd_before_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr == C_TARGET) |-> ($past(mem_re) && $past(mem_addr) == C_OWN_MBX));
endmodule

bind gw_translator gw_translator_checker #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(8 * DATA_BYTES), .N_STATIONS(N_STATIONS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .mbx_irq(mbx_irq),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_len(tx_len),
  .tx_data(tx_data), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .lookup_err(lookup_err)
);

// File: tb/gw_translator_bench.sv
module gw_translator_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [10:0] rx_id = '0;
  logic [3:0]  rx_len = '0;
  logic [63:0] rx_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [10:0] tx_id;
  logic [3:0]  tx_len;
  logic [63:0] tx_data;
  logic        irq;
  logic [9:0]  mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  rdata;
  logic        lookup_err;

  gw_translator u_gw_translator (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_id(rx_id), .rx_len(rx_len), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data),
    .mbx_irq(irq), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(rdata), .lookup_err(lookup_err)
  );

  // Shared memory model with the far side's host port and doorbell.
  logic [7:0] ram [0:1023];
  logic       h_we = 1'b0;
  logic [9:0] h_addr = '0;
  logic [7:0] h_data = '0;
  logic       h_irq = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      rdata <= 8'h00;
      for (int i = 0; i < 1024; i++) ram[i] <= 8'h00;
    end else begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (h_we)   ram[h_addr]   <= h_data;
      if (mem_re) rdata <= ram[mem_addr];
      if (h_irq) irq <= 1'b1;
      else if (mem_re && mem_addr == 10'h3FE) irq <= 1'b0;
    end
  end

  int total = 0, bad = 0;
  int wr_seen = 0, tx_seen = 0, err_seen = 0, wr_at_tx = 0;
  bit done = 1'b0;
  logic [17:0] exp_wr[$];
  logic [78:0] exp_tx[$];
  logic [17:0] e_wr;
  logic [78:0] e_tx;

  task automatic check(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: samples at the falling edge, between active edges.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        wr_seen++;
        if (exp_wr.size() == 0)
          check(1'b0, "R11 unexpected write", {62'd0, mem_addr, mem_wdata}, 80'd0);
        else begin
          e_wr = exp_wr.pop_front();
          check({mem_addr, mem_wdata} == e_wr, "R2 R3 write sequence",
                {62'd0, mem_addr, mem_wdata}, {62'd0, e_wr});
        end
      end
      if (tx_valid && tx_ready) begin
        tx_seen++;
        wr_at_tx = wr_seen;
        if (exp_tx.size() == 0)
          check(1'b0, "R8 unexpected frame", {1'b0, tx_id, tx_len, tx_data}, 80'd0);
        else begin
          e_tx = exp_tx.pop_front();
          check({tx_id, tx_len, tx_data} == e_tx, "R6 R7 outgoing frame",
                {1'b0, tx_id, tx_len, tx_data}, {1'b0, e_tx});
        end
      end
      if (lookup_err) err_seen++;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic settle(input int n);
    repeat (n) tick();
  endtask

  task automatic send_rx(input logic [10:0] id, input logic [3:0] len,
                         input logic [63:0] data);
    rx_id = id; rx_len = len; rx_data = data; rx_valid = 1'b1;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  task automatic host_wr(input logic [9:0] a, input logic [7:0] d);
    h_we = 1'b1; h_addr = a; h_data = d;
    tick();
    h_we = 1'b0;
  endtask

  task automatic ring(input logic [7:0] cmd, input logic [7:0] stn);
    host_wr(10'h3FE, cmd);
    host_wr(10'h3FD, stn);
    h_irq = 1'b1;
    tick();
    h_irq = 1'b0;
  endtask

  task automatic expect_w(input logic [9:0] a, input logic [7:0] d);
    exp_wr.push_back({a, d});
  endtask

  task automatic drained(input string req);
    check(exp_wr.size() == 0 && exp_tx.size() == 0, req,
          {48'd0, exp_wr.size(), 32'd0} | 80'(exp_tx.size()), 80'd0);
  endtask

  initial begin
    int wr0, err0, tx0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!tx_valid && !mem_we && !mem_re && !lookup_err && rx_ready, "R1 reset outputs",
          {75'd0, tx_valid, mem_we, mem_re, lookup_err, rx_ready}, 80'h1);
    tick();

    // R2: data delivery for station 5
    expect_w(10'd10, 8'hAA); expect_w(10'd11, 8'h55);
    expect_w(10'h3FC, 8'h05); expect_w(10'h3FF, 8'h00);
    send_rx(11'd5, 4'd3, 64'h55AA00);
    @(negedge clk);
    check(!rx_ready, "R11 busy while processing", {79'd0, rx_ready}, 80'd0);
    settle(10);
    drained("R2 data delivery station 5");

    // R2: highest station, full-length frame
    expect_w(10'd254, 8'h11); expect_w(10'd255, 8'h22);
    expect_w(10'h3FC, 8'h7F); expect_w(10'h3FF, 8'h00);
    send_rx(11'd127, 4'd8, 64'h7766554433221100);
    settle(10);
    drained("R2 data delivery station 127");

    // R3: request frame
    expect_w(10'h3FC, 8'h33); expect_w(10'h3FF, 8'hFF);
    send_rx(11'd9, 4'd2, 64'h33FF);
    settle(10);
    drained("R3 request forwarding");

    // R4: discards
    wr0 = wr_seen; err0 = err_seen;
    send_rx(11'd4, 4'd3, 64'h665501);
    settle(6);
    send_rx(11'd4, 4'd2, 64'h665500);
    settle(6);
    send_rx(11'd4, 4'd1, 64'h0000FF);
    settle(6);
    check(wr_seen == wr0 && err_seen == err0, "R4 discarded frames leave memory alone",
          80'(wr_seen - wr0), 80'd0);
    check(ram[8] == 8'h00 && ram[10'h3FC] == 8'h33, "R4 memory content unchanged",
          {64'd0, ram[8], ram[10'h3FC]}, {64'd0, 8'h00, 8'h33});

    // R5: receive lookup miss
    wr0 = wr_seen; err0 = err_seen;
    send_rx(11'd128, 4'd3, 64'h0201_00);
    settle(8);
    check(wr_seen == wr0 && err_seen == err0 + 1, "R5 miss drops and pulses once",
          80'(err_seen - err0), 80'd1);

    // R6: doorbell data fetch for station 5
    exp_tx.push_back({11'd5, 4'd3, 64'h55AA00});
    ring(8'h00, 8'h05);
    settle(12);
    drained("R6 data fetch frame");
    check(irq == 1'b0, "R6 doorbell cleared by reading 3FEH", {79'd0, irq}, 80'd0);

    // R7 and R9: request frame under back-pressure
    tx_ready = 1'b0;
    exp_tx.push_back({11'h042, 4'd2, 64'h42FF});
    ring(8'hFF, 8'h42);
    settle(6);
    @(negedge clk);
    check(tx_valid && tx_id == 11'h042 && tx_len == 4'd2 && tx_data == 64'h42FF,
          "R7 request frame content", {1'b0, tx_id, tx_len, tx_data},
          {1'b0, 11'h042, 4'd2, 64'h42FF});
    settle(5);
    @(negedge clk);
    check(tx_valid && tx_data == 64'h42FF && tx_id == 11'h042, "R9 frame held while stalled",
          {1'b0, tx_id, tx_len, tx_data}, {1'b0, 11'h042, 4'd2, 64'h42FF});
    tx0 = tx_seen;
    tick();
    tx_ready = 1'b1;
    settle(4);
    check(tx_seen == tx0 + 1 && !tx_valid, "R9 single transfer after release",
          80'(tx_seen - tx0), 80'd1);

    // R8: unknown doorbell code and doorbell lookup miss
    tx0 = tx_seen; err0 = err_seen;
    ring(8'h5A, 8'h07);
    settle(10);
    check(tx_seen == tx0 && err_seen == err0 && irq == 1'b0, "R8 unknown code gives no frame",
          80'(tx_seen - tx0), 80'd0);
    ring(8'h00, 8'd200);
    settle(10);
    check(tx_seen == tx0 && err_seen == err0 + 1, "R8 doorbell miss pulses error",
          80'(err_seen - err0), 80'd1);

    // R10: doorbell pending together with a waiting frame
    exp_tx.push_back({11'h011, 4'd2, 64'h11FF});
    expect_w(10'd6, 8'hC1); expect_w(10'd7, 8'hC2);
    expect_w(10'h3FC, 8'h03); expect_w(10'h3FF, 8'h00);
    wr0 = wr_seen;
    ring(8'hFF, 8'h11);
    rx_id = 11'd3; rx_len = 4'd3; rx_data = 64'hC2C100; rx_valid = 1'b1;
    @(negedge clk);
    check(!rx_ready, "R10 frame held off while doorbell pending", {79'd0, rx_ready}, 80'd0);
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #2;
    rx_valid = 1'b0;
    settle(12);
    check(wr_at_tx == wr0, "R10 doorbell frame before any frame write",
          80'(wr_at_tx - wr0), 80'd0);
    drained("R10 both jobs completed");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule